// File: doc/BRIEF.md
# UART Modem Loopback Controller

This block provides the internal loopback path of a UART. A control-register value, held here after each control write, carries a loopback-enable bit and four software-driven modem outputs. While loopback is on, those outputs are presented as the modem-status flags, and the four modem-status interrupt bits are rebuilt from them on every control write. Each transmit write and each rising edge of the line-control send-break bit is also turned into an entry pushed into the receive buffer.

While loopback is off, the modem-status flags come from the external modem pins through a synchronizer. Characters and break events from the external line are pushed into the receive buffer, and transmit writes and send-break edges push nothing. Bit-level serial timing is not modelled. One entry at most is pushed per cycle, one cycle after the event that causes it.

Top module: `uart_loopback_ctl`

## Requirements
- R1: While loopback is on, the flags follow the held control value: flag bit 3 (data-set-ready) = control bit 10, flag bit 2 (carrier detect) = control bit 12, flag bit 1 (clear-to-send) = control bit 11, flag bit 0 (ring indicator) = control bit 13. Loopback enable is control bit 7.
- R2: A control write with bit 7 set shows its mapping on the flags in the next cycle, including a write whose only set bit is bit 7.
- R3: A control write with bit 7 set clears all four interrupt bits and then sets each bit whose matching looped flag is high, using the flag bit order of R1. The result is visible in the next cycle.
- R4: While loopback is on, a transmit write pushes its byte one cycle later with the break marker low. While loopback is off, a transmit write pushes nothing.
- R5: While loopback is off, an external line character is pushed one cycle later. While loopback is on, it is discarded and nothing is pushed.
- R6: While loopback is on, a 0-to-1 change of the send-break input pushes data 0x00 with the break marker high. Holding the input high pushes nothing more, and the same change while loopback is off pushes nothing.
- R7: An external break event pushes data 0x00 with the break marker high only while loopback is off.
- R8: While loopback is off, the flags equal the external modem pins delayed by SYNC_STAGES flops, with the same bit order. While loopback is on, the pins have no effect on the flags.
- R9: A one in an interrupt-clear bit clears that interrupt bit in the next cycle. A control write with bit 7 set in the same cycle takes precedence.
- R10: If a break and a character fall in the same cycle, only the break entry is pushed.
- R11: After reset, the flags, the interrupt bits and the push outputs are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 16 | Control value written |
| ms_clr | input | 4 | Modem-status interrupt clear, one bit per interrupt |
| tx_wr | input | 1 | Transmit data write strobe |
| tx_data | input | 8 | Transmit byte |
| rx_line_vld | input | 1 | Character received from the external line |
| rx_line_data | input | 8 | External line character |
| brk_ctl | input | 1 | Send-break bit of line control (level) |
| line_brk | input | 1 | Break event from the external line (pulse) |
| modem_pins | input | 4 | External modem status pins {dsr, dcd, cts, ri} |
| push_vld | output | 1 | Receive-buffer push strobe |
| push_data | output | 8 | Pushed byte |
| push_brk | output | 1 | Break marker of the pushed entry |
| mdm_flags | output | 4 | Modem-status flags {dsr, dcd, cts, ri} |
| ms_irq | output | 4 | Modem-status interrupt bits {dsr, dcd, cts, ri} |

## Verification
The bench first drives the external pins to a non-zero pattern and then writes only the loopback-enable bit. A design that delays the mapping or leaves the pins selected would show the pin values instead of zero. It permutes the four modem outputs one at a time, so a swapped pair in the mapping shows up as a wrong flag. It also issues an interrupt clear in the same cycle as a rebuilding write, where a wrong precedence would drop a bit. It holds the send-break input high for several cycles, where an edge detector that had become a level test would push repeated break entries. It also raises break and data in the same cycle, where a wrong arbiter would push the character or both.

// File: rtl/uart_loopback_pkg.sv
package uart_loopback_pkg;
  localparam int CTRL_W   = 16;
  localparam int LBE_BIT  = 7;
  localparam int DTR_BIT  = 10;
  localparam int RTS_BIT  = 11;
  localparam int OUT1_BIT = 12;
  localparam int OUT2_BIT = 13;

  localparam int MS_W   = 4;
  localparam int MS_RI  = 0;
  localparam int MS_CTS = 1;
  localparam int MS_DCD = 2;
  localparam int MS_DSR = 3;

  // Route software modem outputs onto the status flag positions.
  function automatic logic [MS_W-1:0] loop_map(input logic [CTRL_W-1:0] c);
    logic [MS_W-1:0] f;
    f         = '0;
    f[MS_DSR] = c[DTR_BIT];
    f[MS_DCD] = c[OUT1_BIT];
    f[MS_CTS] = c[RTS_BIT];
    f[MS_RI]  = c[OUT2_BIT];
    return f;
  endfunction

  function automatic logic loop_on(input logic [CTRL_W-1:0] c);
    return c[LBE_BIT];
  endfunction
endpackage

// File: rtl/uart_lbk_ctrl_reg.sv
module uart_lbk_ctrl_reg
  import uart_loopback_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  input  logic [MS_W-1:0]   ms_clr,
  output logic              lbk,
  output logic [MS_W-1:0]   loop_flags,
  output logic [MS_W-1:0]   ms_irq,
  output logic              rebuild_evt
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [MS_W-1:0]   irq_q;

  assign rebuild_evt = ctrl_wr && loop_on(ctrl_wdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_wr) begin
      ctrl_q <= ctrl_wdata;
    end
  end

  // A rebuilding write overrides any clear in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= '0;
    end else if (rebuild_evt) begin
      irq_q <= loop_map(ctrl_wdata);
    end else begin
      irq_q <= irq_q & ~ms_clr;
    end
  end

  assign lbk        = loop_on(ctrl_q);
  assign loop_flags = loop_map(ctrl_q);
  assign ms_irq     = irq_q;
endmodule

// File: rtl/uart_lbk_sync.sv
module uart_lbk_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[i] <= '0;
        else        stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/uart_lbk_push_sel.sv
module uart_lbk_push_sel #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lbk,
  input  logic              tx_wr,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              rx_line_vld,
  input  logic [DATA_W-1:0] rx_line_data,
  input  logic              brk_ctl,
  input  logic              line_brk,
  output logic              push_vld,
  output logic [DATA_W-1:0] push_data,
  output logic              push_brk,
  output logic              brk_rise
);
  logic              brk_prev;
  logic              nxt_vld;
  logic              nxt_brk;
  logic [DATA_W-1:0] nxt_data;

  assign brk_rise = brk_ctl && !brk_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) brk_prev <= 1'b0;
    else        brk_prev <= brk_ctl;
  end

  // Break entries win over characters when both land in one cycle.
  always_comb begin
    nxt_vld  = 1'b0;
    nxt_brk  = 1'b0;
    nxt_data = '0;
    if (lbk) begin
      if (brk_rise) begin
        nxt_vld = 1'b1;
        nxt_brk = 1'b1;
      end else if (tx_wr) begin
        nxt_vld  = 1'b1;
        nxt_data = tx_data;
      end
    end else begin
      if (line_brk) begin
        nxt_vld = 1'b1;
        nxt_brk = 1'b1;
      end else if (rx_line_vld) begin
        nxt_vld  = 1'b1;
        nxt_data = rx_line_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      push_vld  <= 1'b0;
      push_brk  <= 1'b0;
      push_data <= '0;
    end else begin
      push_vld  <= nxt_vld;
      push_brk  <= nxt_brk;
      push_data <= nxt_data;
    end
  end
endmodule

// File: rtl/uart_loopback_ctl.sv
module uart_loopback_ctl
  import uart_loopback_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  input  logic [MS_W-1:0]   ms_clr,
  input  logic              tx_wr,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              rx_line_vld,
  input  logic [DATA_W-1:0] rx_line_data,
  input  logic              brk_ctl,
  input  logic              line_brk,
  input  logic [MS_W-1:0]   modem_pins,
  output logic              push_vld,
  output logic [DATA_W-1:0] push_data,
  output logic              push_brk,
  output logic [MS_W-1:0]   mdm_flags,
  output logic [MS_W-1:0]   ms_irq
);
  logic            lbk_w;
  logic            brk_rise_w;
  logic            rebuild_w;
  logic [MS_W-1:0] loop_flags_w;
  logic [MS_W-1:0] pins_sync_w;

  uart_lbk_ctrl_reg u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_wr    (ctrl_wr),
    .ctrl_wdata (ctrl_wdata),
    .ms_clr     (ms_clr),
    .lbk        (lbk_w),
    .loop_flags (loop_flags_w),
    .ms_irq     (ms_irq),
    .rebuild_evt(rebuild_w)
  );

  uart_lbk_sync #(.W(MS_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (modem_pins),
    .q    (pins_sync_w)
  );

  uart_lbk_push_sel #(.DATA_W(DATA_W)) u_push (
    .clk         (clk),
    .rst_n       (rst_n),
    .lbk         (lbk_w),
    .tx_wr       (tx_wr),
    .tx_data     (tx_data),
    .rx_line_vld (rx_line_vld),
    .rx_line_data(rx_line_data),
    .brk_ctl     (brk_ctl),
    .line_brk    (line_brk),
    .push_vld    (push_vld),
    .push_data   (push_data),
    .push_brk    (push_brk),
    .brk_rise    (brk_rise_w)
  );

  assign mdm_flags = lbk_w ? loop_flags_w : pins_sync_w;
endmodule

// File: rtl/uart_loopback_chk.sv
module uart_loopback_chk
  import uart_loopback_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ctrl_wr,
  input logic [CTRL_W-1:0] ctrl_wdata,
  input logic [MS_W-1:0]   ms_clr,
  input logic              tx_wr,
  input logic [DATA_W-1:0] tx_data,
  input logic              line_brk,
  input logic              push_vld,
  input logic [DATA_W-1:0] push_data,
  input logic              push_brk,
  input logic [MS_W-1:0]   mdm_flags,
  input logic [MS_W-1:0]   ms_irq,
  input logic              lbk,
  input logic              brk_rise
);
  p_ctrl_map_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr && ctrl_wdata[LBE_BIT] |=>
      mdm_flags == {$past(ctrl_wdata[DTR_BIT]), $past(ctrl_wdata[OUT1_BIT]),
                    $past(ctrl_wdata[RTS_BIT]), $past(ctrl_wdata[OUT2_BIT])});

  p_irq_rebuild_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr && ctrl_wdata[LBE_BIT] |=> ms_irq == mdm_flags);

  p_tx_loop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lbk && tx_wr && !brk_rise |=> push_vld && !push_brk && push_data == $past(tx_data));

  p_rx_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lbk && !tx_wr && !brk_rise |=> !push_vld);

  p_brk_loop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lbk && brk_rise |=> push_vld && push_brk && push_data == '0);

  p_line_brk_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !lbk && line_brk |=> push_vld && push_brk && push_data == '0);

  p_irq_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctrl_wr && ctrl_wdata[LBE_BIT]) |=> (ms_irq & $past(ms_clr)) == '0);
endmodule

bind uart_loopback_ctl uart_loopback_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ctrl_wr   (ctrl_wr),
  .ctrl_wdata(ctrl_wdata),
  .ms_clr    (ms_clr),
  .tx_wr     (tx_wr),
  .tx_data   (tx_data),
  .line_brk  (line_brk),
  .push_vld  (push_vld),
  .push_data (push_data),
  .push_brk  (push_brk),
  .mdm_flags (mdm_flags),
  .ms_irq    (ms_irq),
  .lbk       (lbk_w),
  .brk_rise  (brk_rise_w)
);

// File: tb/uart_loopback_ctl_bench.sv
`timescale 1ns/1ps
module uart_loopback_ctl_bench;
  localparam int DW   = 8;
  localparam int SYNC = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_wr = 1'b0;
  logic [15:0] ctrl_wdata = '0;
  logic [3:0]  ms_clr = '0;
  logic        tx_wr = 1'b0;
  logic [7:0]  tx_data = '0;
  logic        rx_line_vld = 1'b0;
  logic [7:0]  rx_line_data = '0;
  logic        brk_ctl = 1'b0;
  logic        line_brk = 1'b0;
  logic [3:0]  modem_pins = '0;
  logic        push_vld;
  logic [7:0]  push_data;
  logic        push_brk;
  logic [3:0]  mdm_flags;
  logic [3:0]  ms_irq;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  uart_loopback_ctl #(.DATA_W(DW), .SYNC_STAGES(SYNC)) u_uart_loopback_ctl (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
    .ms_clr(ms_clr), .tx_wr(tx_wr), .tx_data(tx_data),
    .rx_line_vld(rx_line_vld), .rx_line_data(rx_line_data),
    .brk_ctl(brk_ctl), .line_brk(line_brk), .modem_pins(modem_pins),
    .push_vld(push_vld), .push_data(push_data), .push_brk(push_brk),
    .mdm_flags(mdm_flags), .ms_irq(ms_irq)
  );

  // Behavioural reference: state as plain variables, sync as a queue.
  logic [15:0] m_ctrl;
  logic [3:0]  m_irq;
  logic        m_bprev;
  logic        m_pv, m_pb;
  logic [7:0]  m_pd;
  logic [3:0]  m_pinq[$];
  string       m_ptag = "R11";
  string       m_itag = "R11";

  function automatic logic [3:0] ref_map(input logic [15:0] c);
    return {c[10], c[12], c[11], c[13]};
  endfunction

  function automatic logic [3:0] ref_flags();
    if (m_ctrl[7]) return ref_map(m_ctrl);
    return m_pinq[0];
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl <= '0; m_irq <= '0; m_bprev <= 1'b0;
      m_pv <= 1'b0; m_pb <= 1'b0; m_pd <= '0;
      m_pinq = {};
      for (int i = 0; i < SYNC; i++) m_pinq.push_back(4'h0);
    end else begin : upd
      logic rise;
      rise = brk_ctl && !m_bprev;
      m_pv <= 1'b0; m_pb <= 1'b0; m_pd <= '0; m_ptag <= "R5";
      if (m_ctrl[7]) begin
        if (rise) begin
          m_pv <= 1'b1; m_pb <= 1'b1; m_ptag <= tx_wr ? "R10" : "R6";
        end else if (tx_wr) begin
          m_pv <= 1'b1; m_pd <= tx_data; m_ptag <= "R4";
        end
      end else begin
        if (line_brk) begin
          m_pv <= 1'b1; m_pb <= 1'b1; m_ptag <= rx_line_vld ? "R10" : "R7";
        end else if (rx_line_vld) begin
          m_pv <= 1'b1; m_pd <= rx_line_data; m_ptag <= "R5";
        end
      end
      m_bprev <= brk_ctl;
      m_pinq.push_back(modem_pins);
      void'(m_pinq.pop_front());
      if (ctrl_wr) m_ctrl <= ctrl_wdata;
      if (ctrl_wr && ctrl_wdata[7]) begin
        m_irq <= ref_map(ctrl_wdata); m_itag <= "R3";
      end else if (|ms_clr) begin
        m_irq <= m_irq & ~ms_clr; m_itag <= "R9";
      end
    end
  end

  // Per-cycle comparison, away from the active edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(m_ptag, {31'd0, push_vld}, {31'd0, m_pv});
      check(m_ptag, {31'd0, push_brk}, {31'd0, m_pb});
      check(m_ptag, {24'd0, push_data}, {24'd0, m_pd});
      check(m_ctrl[7] ? "R1" : "R8", {28'd0, mdm_flags}, {28'd0, ref_flags()});
      check(m_itag, {28'd0, ms_irq}, {28'd0, m_irq});
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_ctrl(input logic [15:0] v, input logic [3:0] clr);
    ctrl_wr = 1'b1; ctrl_wdata = v; ms_clr = clr;
    cyc(1);
    ctrl_wr = 1'b0; ms_clr = '0;
  endtask

  task automatic send_tx(input logic [7:0] b);
    tx_wr = 1'b1; tx_data = b; cyc(1); tx_wr = 1'b0;
  endtask

  task automatic line_char(input logic [7:0] b);
    rx_line_vld = 1'b1; rx_line_data = b; cyc(1); rx_line_vld = 1'b0;
  endtask

  task automatic line_break();
    line_brk = 1'b1; cyc(1); line_brk = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    // R11: reset state
    check("R11", {28'd0, mdm_flags, push_vld, push_brk, ms_irq}, 32'd0);
    // R8: external pins through the synchronizer
    modem_pins = 4'b1010;
    cyc(1);
    check("R8", {28'd0, mdm_flags}, 32'd0);
    cyc(SYNC);
    check("R8", {28'd0, mdm_flags}, 32'hA);
    // R5, R7, R10 outside loopback
    line_char(8'h5A);
    line_break();
    rx_line_vld = 1'b1; rx_line_data = 8'h11; line_brk = 1'b1;
    cyc(1); rx_line_vld = 1'b0; line_brk = 1'b0;
    // R4 / R6 outside loopback: nothing pushed
    send_tx(8'h33);
    brk_ctl = 1'b1; cyc(2); brk_ctl = 1'b0; cyc(1);
    // R2: only the enable bit
    wr_ctrl(16'h0080, 4'h0);
    check("R2", {28'd0, mdm_flags}, 32'd0);
    check("R2", {28'd0, ms_irq}, 32'd0);
    // R1/R3: RTS + OUT2
    wr_ctrl(16'h0080 | 16'h0800 | 16'h2000, 4'h0);
    check("R1", {28'd0, mdm_flags}, 32'h3);
    check("R3", {28'd0, ms_irq}, 32'h3);
    ms_clr = 4'b0001; cyc(1); ms_clr = '0;
    check("R9", {28'd0, ms_irq}, 32'h2);
    wr_ctrl(16'h0080 | 16'h0400, 4'h0);
    check("R1", {28'd0, mdm_flags}, 32'h8);
    check("R3", {28'd0, ms_irq}, 32'h8);
    // loopback data paths
    send_tx(8'hA5);
    check("R4", {23'd0, push_vld, push_data}, {23'd0, 1'b1, 8'hA5});
    line_char(8'h77);
    check("R5", {31'd0, push_vld}, 32'd0);
    line_break();
    check("R7", {31'd0, push_vld}, 32'd0);
    brk_ctl = 1'b1; tx_wr = 1'b1; tx_data = 8'h9C; cyc(1); tx_wr = 1'b0;
    check("R10", {22'd0, push_vld, push_brk, push_data}, {22'd0, 2'b11, 8'h00});
    cyc(3);
    check("R6", {31'd0, push_vld}, 32'd0);
    brk_ctl = 1'b0; cyc(1);
    brk_ctl = 1'b1; cyc(1);
    check("R6", {22'd0, push_vld, push_brk, push_data}, {22'd0, 2'b11, 8'h00});
    brk_ctl = 1'b0;
    // pins ignored in loopback
    modem_pins = 4'b0101; cyc(4);
    check("R8", {28'd0, mdm_flags}, 32'h8);
    // write rebuild beats a clear in the same cycle
    wr_ctrl(16'h0080 | 16'h1000, 4'hF);
    check("R9", {28'd0, ms_irq}, 32'h4);
    // exit loopback: irq untouched, pins return
    wr_ctrl(16'h0000, 4'h0);
    check("R8", {28'd0, mdm_flags}, 32'h5);
    check("R3", {28'd0, ms_irq}, 32'h4);
    ms_clr = 4'hF; cyc(1); ms_clr = '0;
    line_char(8'hC3);
    check("R5", {23'd0, push_vld, push_data}, {23'd0, 1'b1, 8'hC3});
    send_tx(8'h44);
    check("R4", {31'd0, push_vld}, 32'd0);
    cyc(2);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule